// File: doc/BRIEF.md
# LRU Set-Associative Tag Lookup

This block models whether a memory access hits or misses in a set-associative cache. No data is stored. Each set keeps its tags ordered from most recently used to least recently used. An access names a start address and a byte count. The block works out which line blocks the first and last byte fall in and looks them up. It then reports a single hit or miss outcome and updates the recency order of every set it touched. Allocation does not depend on the kind of access: every miss installs its block, whether the access is a read or a write.

The line-block number is the address shifted right by log2 of the line size. The set is picked by the low bits of that block number. The full block number is kept as the tag. An access that stays within one line gives its answer one cycle after it is accepted. An access that crosses into the next line needs two lookups in two consecutive cycles and gives one combined answer after the second. An access that reaches beyond the next line is rejected with an error pulse.

Top module: `lru_tag_lookup`

## Requirements
- R1: After reset every way of every set is empty, resp_valid_o and err_o are low, and the first access to any block reports a miss.
- R2: The set index is address bits [log2(LINE_BYTES) +: log2(SETS)]. Blocks whose addresses differ by a multiple of LINE_BYTES*SETS compete for the same set.
- R3: The full block number (address >> log2(LINE_BYTES)) is the stored tag, so two blocks in the same set never match each other, and at most one way of a set matches a lookup.
- R4: An access to a block that is present reports resp_hit_o = 1 and makes that block the most recently used entry of its set.
- R5: A miss installs the block as the most recently used entry and evicts the least recently used one. After WAYS further distinct blocks in the same set, the original block misses. Allocation happens on every access, with no read or write distinction.
- R6: A hit in a way other than the most recent one moves that block to the front. Only the entries that were more recent shift back by one place, so the entries that were older keep their places.
- R7: An access whose first byte (addr) and last byte (addr + size − 1) lie in the same block raises resp_valid_o in the cycle after it is accepted.
- R8: An access whose last byte lies in the next block looks up the first block and then the second, always both, each updating recency. resp_valid_o rises two cycles after acceptance. resp_hit_o is 1 only when both lookups hit.
- R9: An access whose last byte lies more than one block beyond the first raises err_o for one cycle, one cycle after acceptance. It gives no response and leaves the tag state unchanged.
- R10: A request presented during the second lookup of a line-crossing access is ignored. It gives no response and no error, and it changes no tag state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | ADDR_W | Byte address of the first byte |
| req_size_i | input | SIZE_W | Access length in bytes (1 or more) |
| resp_valid_o | output | 1 | Outcome valid (one-cycle pulse) |
| resp_hit_o | output | 1 | 1 = hit, 0 = miss; meaningful with resp_valid_o |
| err_o | output | 1 | Access spans more than two blocks |

## Verification
Two things can land in the same cycle. One is the second lookup of a line-crossing access together with a newly presented request. The other is the response of one access together with the acceptance of the next, when both touch the same set. The bench provokes the first by driving a request, sometimes to an untouched block, during the second lookup. It judges the result by the absence of any response or error and by a later access to that block still missing. The second comes from back-to-back requests with no idle cycle, taken from a small address range so that sets collide. A bench reference model checks every outcome against the recency order it keeps.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic [1:0] {
    SPAN_ONE = 2'd0,
    SPAN_TWO = 2'd1,
    SPAN_BAD = 2'd2
  } span_e;
endpackage

// File: rtl/lru_span_decode.sv
module lru_span_decode
  import lru_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  parameter int LINE_W = 4,
  localparam int BLK_W = ADDR_W - LINE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [BLK_W-1:0]  blk_o,
  output logic [BLK_W-1:0]  nxt_blk_o,
  output span_e             span_o
);
  logic [ADDR_W-1:0] last_addr;
  logic [BLK_W-1:0]  last_blk;

  assign last_addr = addr_i + ADDR_W'(size_i) - ADDR_W'(1);
  assign blk_o     = addr_i[ADDR_W-1:LINE_W];
  assign last_blk  = last_addr[ADDR_W-1:LINE_W];
  assign nxt_blk_o = blk_o + BLK_W'(1);

  always_comb begin
    if (last_blk == blk_o)          span_o = SPAN_ONE;
    else if (last_blk == nxt_blk_o) span_o = SPAN_TWO;
    else                            span_o = SPAN_BAD;
  end
endmodule

// File: rtl/lru_way_match.sv
module lru_way_match #(
  parameter int WAYS  = 4,
  parameter int BLK_W = 28,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][BLK_W-1:0] tags_i,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [BLK_W-1:0]           blk_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o
);
  for (genvar k = 0; k < WAYS; k++) begin : g_cmp
    assign hit_vec_o[k] = vld_i[k] && (tags_i[k] == blk_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_way_o = '0;
    for (int k = WAYS - 1; k >= 0; k--) begin
      if (hit_vec_o[k]) hit_way_o = WAY_W'(k);
    end
  end
endmodule

// File: rtl/lru_order_update.sv
module lru_order_update #(
  parameter int WAYS  = 4,
  parameter int BLK_W = 28,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][BLK_W-1:0] tags_i,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [BLK_W-1:0]           blk_i,
  input  logic                       hit_i,
  input  logic [WAY_W-1:0]           hit_way_i,
  output logic [WAYS-1:0][BLK_W-1:0] tags_o,
  output logic [WAYS-1:0]            vld_o
);
  // Front slot always receives the referenced block; older slots shift up to
  // the hit position, or across the whole row on a miss (tail drops out).
  assign tags_o[0] = blk_i;
  assign vld_o[0]  = 1'b1;

  for (genvar k = 1; k < WAYS; k++) begin : g_slot
    logic shift;
    assign shift     = !hit_i || (WAY_W'(k) <= hit_way_i);
    assign tags_o[k] = shift ? tags_i[k-1] : tags_i[k];
    assign vld_o[k]  = shift ? vld_i[k-1]  : vld_i[k];
  end
endmodule

// File: rtl/lru_tag_lookup.sv
module lru_tag_lookup
  import lru_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 5,
  parameter int LINE_BYTES = 16,
  parameter int WAYS       = 4,
  parameter int SETS       = 8,
  localparam int LINE_W = $clog2(LINE_BYTES),
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int BLK_W  = ADDR_W - LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              err_o
);
  logic [SETS-1:0][WAYS-1:0][BLK_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0]            vld_q;

  logic             pend_q;
  logic [BLK_W-1:0] pend_blk_q;
  logic             pend_miss_q;

  logic [BLK_W-1:0] req_blk, req_nxt_blk, lk_blk;
  span_e            req_span;
  logic             req_take, lk_en;
  logic [SET_W-1:0] set_idx;

  logic [WAYS-1:0]            hit_vec;
  logic                       lk_hit;
  logic [WAY_W-1:0]           lk_way;
  logic [WAYS-1:0][BLK_W-1:0] new_tags;
  logic [WAYS-1:0]            new_vld;

  lru_span_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_W(LINE_W)
  ) u_span (
    .addr_i    (req_addr_i),
    .size_i    (req_size_i),
    .blk_o     (req_blk),
    .nxt_blk_o (req_nxt_blk),
    .span_o    (req_span)
  );

  // Requests are dropped while the second half of a crossing access runs.
  assign req_take = req_valid_i && !pend_q;
  assign lk_en    = pend_q || (req_take && (req_span != SPAN_BAD));
  assign lk_blk   = pend_q ? pend_blk_q : req_blk;
  assign set_idx  = lk_blk[SET_W-1:0];

  lru_way_match #(.WAYS(WAYS), .BLK_W(BLK_W)) u_match (
    .tags_i    (tag_q[set_idx]),
    .vld_i     (vld_q[set_idx]),
    .blk_i     (lk_blk),
    .hit_vec_o (hit_vec),
    .hit_o     (lk_hit),
    .hit_way_o (lk_way)
  );

  lru_order_update #(.WAYS(WAYS), .BLK_W(BLK_W)) u_order (
    .tags_i    (tag_q[set_idx]),
    .vld_i     (vld_q[set_idx]),
    .blk_i     (lk_blk),
    .hit_i     (lk_hit),
    .hit_way_i (lk_way),
    .tags_o    (new_tags),
    .vld_o     (new_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      vld_q <= '0;
    end else if (lk_en) begin
      tag_q[set_idx] <= new_tags;
      vld_q[set_idx] <= new_vld;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pend_blk_q   <= '0;
      pend_miss_q  <= 1'b0;
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      err_o        <= 1'b0;
      if (pend_q) begin
        pend_q       <= 1'b0;
        resp_valid_o <= 1'b1;
        resp_hit_o   <= !pend_miss_q && lk_hit;
      end else if (req_take) begin
        unique case (req_span)
          SPAN_ONE: begin
            resp_valid_o <= 1'b1;
            resp_hit_o   <= lk_hit;
          end
          SPAN_TWO: begin
            pend_q      <= 1'b1;
            pend_blk_q  <= req_nxt_blk;
            pend_miss_q <= !lk_hit;
          end
          default: err_o <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/lru_tag_lookup_chk.sv
module lru_tag_lookup_chk #(
  parameter int WAYS = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            resp_valid_o,
  input logic            err_o,
  input logic            pend_q,
  input logic [WAYS-1:0] hit_vec
);
  assert_single_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  assert_accept_answers_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !pend_q) |=> (resp_valid_o || err_o || pend_q));

  assert_no_spurious_resp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(req_valid_i || pend_q));

  assert_second_half_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> (resp_valid_o && !pend_q));

  assert_err_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!resp_valid_o && $past(req_valid_i && !pend_q)));

  assert_ignored_no_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !err_o);
endmodule

bind lru_tag_lookup lru_tag_lookup_chk #(.WAYS(WAYS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .resp_valid_o (resp_valid_o),
  .err_o        (err_o),
  .pend_q       (pend_q),
  .hit_vec      (hit_vec)
);

// File: tb/lru_tag_lookup_bench.sv
module lru_tag_lookup_bench;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 5;
  localparam int LINE_B = 16;
  localparam int WAYS   = 4;
  localparam int SETS   = 8;
  localparam int LW     = $clog2(LINE_B);
  localparam int BLK_W  = ADDR_W - LW;
  localparam int STRIDE = LINE_B * SETS;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [SIZE_W-1:0] req_size_i = '0;
  logic              resp_valid_o, resp_hit_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  lru_tag_lookup #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_B), .WAYS(WAYS), .SETS(SETS)
  ) u_lru_tag_lookup (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .err_o(err_o)
  );

  always #4ns clk_i = ~clk_i;

  // reference recency model, index 0 = most recent
  logic [BLK_W-1:0] m_tag [SETS][WAYS];
  bit               m_vld [SETS][WAYS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_ref(input logic [BLK_W-1:0] blk, output bit miss);
    int s, lim;
    s = int'(blk % SETS);
    lim = WAYS - 1;
    miss = 1'b1;
    for (int k = WAYS - 1; k >= 0; k--)
      if (m_vld[s][k] && m_tag[s][k] == blk) begin lim = k; miss = 1'b0; end
    for (int k = lim; k > 0; k--) begin
      m_tag[s][k] = m_tag[s][k-1];
      m_vld[s][k] = m_vld[s][k-1];
    end
    m_tag[s][0] = blk;
    m_vld[s][0] = 1'b1;
  endtask

  // Drive at a negedge; returns at the negedge where the outcome is sampled.
  task automatic access(input logic [ADDR_W-1:0] a, input int sz, input string req,
                        input bit inj = 0, input logic [ADDR_W-1:0] inj_a = '0);
    logic [ADDR_W-1:0] last;
    logic [BLK_W-1:0]  b1, b2;
    bit m1, m2;
    last = a + ADDR_W'(sz) - ADDR_W'(1);
    b1 = a[ADDR_W-1:LW];
    b2 = last[ADDR_W-1:LW];
    req_valid_i = 1'b1;
    req_addr_i  = a;
    req_size_i  = SIZE_W'(sz);
    @(negedge clk_i);
    if (b1 == b2) begin
      m_ref(b1, m1);
      chk(resp_valid_o === 1'b1 && err_o === 1'b0, {req, " R7 valid"}, resp_valid_o, 1);
      chk(resp_hit_o === !m1, {req, " hit"}, resp_hit_o, !m1);
    end else if (b2 == b1 + BLK_W'(1)) begin
      chk(resp_valid_o === 1'b0 && err_o === 1'b0, {req, " R8 mid"}, resp_valid_o, 0);
      if (inj) begin
        req_addr_i = inj_a;
        req_size_i = SIZE_W'(1);
      end else req_valid_i = 1'b0;
      @(negedge clk_i);
      m_ref(b1, m1);
      m_ref(b2, m2);
      chk(resp_valid_o === 1'b1 && err_o === 1'b0, {req, " R8 R10 valid"}, resp_valid_o, 1);
      chk(resp_hit_o === !(m1 || m2), {req, " R8 hit"}, resp_hit_o, !(m1 || m2));
    end else begin
      chk(err_o === 1'b1 && resp_valid_o === 1'b0, {req, " R9 err"}, err_o, 1);
    end
    req_valid_i = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1d5a;
    void'($urandom(seed));
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++) begin m_tag[s][k] = '0; m_vld[s][k] = 0; end
    repeat (3) @(negedge clk_i);
    chk(resp_valid_o === 1'b0 && err_o === 1'b0, "R1 reset outputs", resp_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(resp_valid_o === 1'b0 && err_o === 1'b0, "R1 idle after reset", err_o, 0);

    access(32'h0, 4, "R1 first miss");
    access(32'h0, 4, "R4 repeat hit");
    // R5/R2/R3: fill set 0 with conflicting blocks, evict the oldest
    for (int i = 1; i <= WAYS; i++) access(32'(i * STRIDE), 1, "R2 R5 fill");
    access(32'h0, 1, "R5 evicted");
    // R6: hit old way, then one new block evicts the next oldest, not it
    for (int i = 0; i < WAYS; i++) access(32'h10 + 32'(i * STRIDE), 2, "R6 fill");
    access(32'h10, 2, "R6 promote");
    access(32'h10 + 32'(9 * STRIDE), 2, "R6 insert");
    access(32'h10, 2, "R6 kept");
    access(32'h10 + 32'(STRIDE), 2, "R6 dropped");
    // R8: crossing accesses, both miss / mixed / both hit
    access(32'h2e, 4, "R8 cross");
    access(32'h2e, 4, "R8 cross again");
    access(32'h3e, 4, "R8 half new");
    // R9: spans three blocks; state must stay intact
    access(32'h2f, 20, "R9 wide");
    access(32'h2e, 4, "R9 state kept");
    // R10: inject a request to an untouched block during the second lookup
    access(32'h4e, 4, "R10 cross", 1, 32'h7000);
    access(32'h7000, 1, "R10 ignored block");

    for (int i = 0; i < 600; i++) begin
      int sz;
      sz = ($urandom % 4 == 0) ? int'($urandom % 31) + 1 : int'($urandom % 8) + 1;
      access(32'($urandom % 2048), sz, "rand", ($urandom % 4) == 0, 32'($urandom % 2048));
    end

    repeat (2) @(negedge clk_i);
    chk(resp_valid_o === 1'b0 && err_o === 1'b0, "R7 quiet at end", resp_valid_o, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule